// File: doc/BRIEF.md
# Oscillator Clock Switch Controller

This block steers a runtime change of the system clock among six source selections built from four oscillators: the fast internal RC (plain or through the PLL), the primary oscillator (plain or through the PLL), the secondary oscillator, and the low-power internal RC. Software writes a requested source into a control register, then sets a start bit. Each register byte lane needs its own unlock key first. The controller checks the request and drops it if it is redundant or illegal. For a legal request it powers up the target oscillator, waits for the crystal start-up timer and the PLL lock where they apply, and counts settling cycles of the new clock. It then moves the clock-select output and clears the start bit.

A configuration input turns the whole feature off. In that state the clock source comes straight from a configuration selection, and the start bit cannot be set. The analog oscillators and the glitch-free clock multiplexer sit outside the block. They are represented only by enable outputs, ready inputs and the clock-select code. The settling count runs on the new clock and returns to the controller through a synchronised toggle handshake.

Top module: `clk_switch_ctrl`

## Requirements
- R1: While `cfgSwDis` is 1, the current-source field and `clkSel` both follow `cfgSrc`, and a value written to the requested-source field starts no switch.
- R2: While `cfgSwDis` is 1, the start bit reads 0 at all times, including after an unlocked write of 1 to it.
- R3: `regRdData` holds the current source at bits [14:12], the requested source at [10:8], the sticky error at bit 6, the lock status at bit 5, the clock-fail flag at bit 3 and the start bit at bit 0; every other bit reads 0. After reset, the current and requested fields both equal `cfgSrc` and all flags are 0.
- R4: A write to the high lane (`regWrHi`, which loads [10:8]) takes effect only after `keyByte` 8'h3C and then 8'hC3 are given with `keyWr` on two consecutive cycles. A write to the low lane (`regWrLo`, where bit 0 sets start) needs 8'h5A and then 8'hA5 in the same way. Each unlock is used up by the next write to its lane. Writes that are not unlocked are ignored.
- R5: A start request whose requested source equals the current source clears the start bit on the next clock and changes nothing else: no busy cycle, and the flags keep their values.
- R6: An accepted request clears the lock status and the clock-fail flag on the clock after the start bit is captured. `clkFailIn` sets the clock-fail flag.
- R7: A target that uses a crystal (codes 2, 3 and 4) waits for `ostReady`. A target that uses the PLL (codes 1 and 3) then waits for `pllLock`, and seeing the lock sets the lock status bit.
- R8: After the target is ready, 10 cycles of `newClk` are counted. When no wait is needed and `newClk` is the same clock as `clk`, `clkSel` and the current field change, and start clears, on the 19th rising edge after the edge that captures the start write. The current source changes at no other time.
- R9: Source codes are 0 internal RC, 1 internal RC with PLL, 2 primary, 3 primary with PLL, 4 secondary, 5 low-power RC. `oscEn` bit 0 is the internal RC, bit 1 the primary, bit 2 the secondary and bit 3 the low-power RC. `pllEn` drives the PLL. The current source and, during a switch, the target are enabled. The old source turns off at commit, except that `keepLprc` holds bit 3 on and `secKeep` holds bit 2 on.
- R10: A request between codes 1 and 3 (in either direction), or to code 6 or 7, clears the start bit, leaves the current source unchanged and sets the sticky error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| newClk | input | 1 | Clock of the oscillator being switched to |
| cfgSwDis | input | 1 | 1 turns switching off (default setting) |
| cfgSrc | input | 3 | Configured source used when switching is off and at reset |
| keyWr | input | 1 | Unlock key byte valid |
| keyByte | input | 8 | Unlock key byte |
| regWrHi | input | 1 | High-lane register write strobe |
| regWrLo | input | 1 | Low-lane register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read value |
| ostReady | input | 1 | Crystal start-up timer expired |
| pllLock | input | 1 | PLL locked |
| clkFailIn | input | 1 | Clock failure pulse from the fail-safe monitor |
| keepLprc | input | 1 | Watchdog, monitor or real-time clock needs the low-power RC |
| secKeep | input | 1 | Software keeps the secondary oscillator enabled |
| oscEn | output | 4 | Per-oscillator enables |
| pllEn | output | 1 | PLL enable |
| clkSel | output | 3 | Clock multiplexer select code |
| busy | output | 1 | A switch is in progress |

## Verification
Two events can collide in the same cycle: a start request being judged against the current source, and a flag update (the clock-fail pulse, or the lock status left over from an earlier PLL switch). The bench sets both flags and then issues a redundant request. It checks, one clock after the capture, that start has cleared while both flags kept their values. It then issues an accepted request and checks, in that same cycle, that both flags were cleared. The switch latency is judged edge by edge: the old select is expected one cycle before the commit edge and the new one at it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int SRC_W = 3;

  localparam logic [SRC_W-1:0] SRC_FRC    = 3'd0;
  localparam logic [SRC_W-1:0] SRC_FRCPLL = 3'd1;
  localparam logic [SRC_W-1:0] SRC_PRI    = 3'd2;
  localparam logic [SRC_W-1:0] SRC_PRIPLL = 3'd3;
  localparam logic [SRC_W-1:0] SRC_SEC    = 3'd4;
  localparam logic [SRC_W-1:0] SRC_LPRC   = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_OST,
    ST_WAIT_PLL,
    ST_SETTLE
  } swState_t;

  typedef struct packed {
    logic abort;
    logic reject;
    logic clrFlags;
    logic setLock;
    logic commit;
  } swStrobe_t;

  function automatic logic isPll(input logic [SRC_W-1:0] s);
    return (s == SRC_FRCPLL) || (s == SRC_PRIPLL);
  endfunction

  function automatic logic isXtal(input logic [SRC_W-1:0] s);
    return (s == SRC_PRI) || (s == SRC_PRIPLL) || (s == SRC_SEC);
  endfunction

  function automatic logic isLegal(input logic [SRC_W-1:0] s);
    return s <= SRC_LPRC;
  endfunction

  // bit0 internal RC, bit1 primary, bit2 secondary, bit3 low-power RC
  function automatic logic [3:0] oscNeed(input logic [SRC_W-1:0] s);
    logic [3:0] n;
    case (s)
      SRC_FRC, SRC_FRCPLL: n = 4'b0001;
      SRC_PRI, SRC_PRIPLL: n = 4'b0010;
      SRC_SEC:             n = 4'b0100;
      SRC_LPRC:            n = 4'b1000;
      default:             n = 4'b0000;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/clksw_settle.sv
module clksw_settle #(
  parameter int SETTLE_CYC  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic newClk,
  input  logic rstN,
  input  logic settleReq,   // toggles once per settle request (clk domain)
  output logic settleDone   // one-cycle pulse in clk domain
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [SYNC_STAGES:0] reqSync;
  logic [SYNC_STAGES:0] doneSync;
  logic [CNT_W-1:0]     cnt;
  logic                 doneTgl;
  logic                 reqEdge;

  assign reqEdge = reqSync[SYNC_STAGES] ^ reqSync[SYNC_STAGES-1];

  // new-clock domain: synchronise request, count settle cycles
  always_ff @(posedge newClk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      cnt     <= '0;
      doneTgl <= 1'b0;
    end else begin
      reqSync <= {reqSync[SYNC_STAGES-1:0], settleReq};
      if (reqEdge) begin
        cnt <= CNT_W'(SETTLE_CYC);
      end else if (cnt != '0) begin
        if (cnt == CNT_W'(1)) doneTgl <= ~doneTgl;
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // back to controller domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneSync <= '0;
    else       doneSync <= {doneSync[SYNC_STAGES-1:0], doneTgl};
  end

  assign settleDone = doneSync[SYNC_STAGES] ^ doneSync[SYNC_STAGES-1];

  p_count_range_r8: assert property (@(posedge newClk) disable iff (!rstN)
    (cnt != '0) |=> (cnt < $past(cnt)) || reqEdge || $past(reqEdge));

endmodule

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter logic [7:0] HI_KEY_A = 8'h3C,
  parameter logic [7:0] HI_KEY_B = 8'hC3,
  parameter logic [7:0] LO_KEY_A = 8'h5A,
  parameter logic [7:0] LO_KEY_B = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSwDis,
  input  logic [SRC_W-1:0] cfgSrc,
  input  logic             keyWr,
  input  logic [7:0]       keyByte,
  input  logic             regWrHi,
  input  logic             regWrLo,
  input  logic [15:0]      regWrData,
  input  logic             clkFailIn,
  input  swStrobe_t        strb,
  input  logic [SRC_W-1:0] tgtSrc,
  output logic [SRC_W-1:0] curEff,
  output logic [SRC_W-1:0] reqSrc,
  output logic             startBit,
  output logic [15:0]      regRdData
);
  localparam int LANES = 2;   // lane 1 = high byte, lane 0 = low byte

  logic [LANES-1:0] laneWr, laneArm, laneStage, laneOk;
  logic [SRC_W-1:0] curSrc;
  logic             lockBit, cfBit, errBit;
  logic             unusedBits;

  assign laneWr     = {regWrHi, regWrLo};
  assign unusedBits = ^{regWrData[15:11], regWrData[7:1]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [7:0] KA = (g == 1) ? HI_KEY_A : LO_KEY_A;
    localparam logic [7:0] KB = (g == 1) ? HI_KEY_B : LO_KEY_B;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneStage[g] <= 1'b0;
        laneArm[g]   <= 1'b0;
      end else begin
        laneStage[g] <= keyWr && (keyByte == KA);
        if (laneWr[g]) laneArm[g] <= 1'b0;
        if (keyWr && laneStage[g] && (keyByte == KB)) laneArm[g] <= 1'b1;
      end
    end
    assign laneOk[g] = laneWr[g] & laneArm[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc   <= cfgSrc;
      reqSrc   <= cfgSrc;
      startBit <= 1'b0;
      lockBit  <= 1'b0;
      cfBit    <= 1'b0;
      errBit   <= 1'b0;
    end else begin
      if (laneOk[1]) reqSrc <= regWrData[10:8];

      if (cfgSwDis)                                startBit <= 1'b0;
      else if (strb.abort || strb.reject || strb.commit) startBit <= 1'b0;
      else if (laneOk[0] && regWrData[0])          startBit <= 1'b1;

      if (cfgSwDis)         curSrc <= cfgSrc;
      else if (strb.commit) curSrc <= tgtSrc;

      if (strb.clrFlags) begin
        lockBit <= 1'b0;
        cfBit   <= 1'b0;
      end else begin
        if (strb.setLock) lockBit <= 1'b1;
        if (clkFailIn)    cfBit   <= 1'b1;
      end

      if (strb.reject) errBit <= 1'b1;
    end
  end

  assign curEff    = cfgSwDis ? cfgSrc : curSrc;
  assign regRdData = {1'b0, curEff, 1'b0, reqSrc, 1'b0, errBit, lockBit,
                      1'b0, cfBit, 2'b00, startBit};

  p_start_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgSwDis |=> !startBit);

  p_cur_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSwDis && !strb.commit) |=> $stable(curSrc));

  p_flags_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFlags |=> (!lockBit && !cfBit));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errBit |=> errBit);

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSwDis,
  input  logic             startBit,
  input  logic [SRC_W-1:0] reqSrc,
  input  logic [SRC_W-1:0] curSrc,
  input  logic             ostReady,
  input  logic             pllLock,
  input  logic             settleDone,
  input  logic             keepLprc,
  input  logic             secKeep,
  output swStrobe_t        strb,
  output logic [SRC_W-1:0] tgtSrc,
  output logic             settleReq,
  output logic             busy,
  output logic [3:0]       oscEn,
  output logic             pllEn
);
  swState_t state, nextState;
  logic     goSettle;

  always_comb begin
    strb      = '0;
    nextState = state;
    goSettle  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startBit && !cfgSwDis) begin
          if (reqSrc == curSrc) begin
            strb.abort = 1'b1;
          end else if (!isLegal(reqSrc) || (isPll(reqSrc) && isPll(curSrc))) begin
            strb.reject = 1'b1;
          end else begin
            strb.clrFlags = 1'b1;
            nextState     = ST_WAIT_OST;
          end
        end
      end
      ST_WAIT_OST: if (!isXtal(tgtSrc) || ostReady) nextState = ST_WAIT_PLL;
      ST_WAIT_PLL: begin
        if (!isPll(tgtSrc) || pllLock) begin
          strb.setLock = isPll(tgtSrc);
          nextState    = ST_SETTLE;
          goSettle     = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settleDone) begin
          strb.commit = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tgtSrc    <= '0;
      settleReq <= 1'b0;
    end else begin
      state <= cfgSwDis ? ST_IDLE : nextState;
      if (strb.clrFlags) tgtSrc <= reqSrc;
      if (goSettle)      settleReq <= ~settleReq;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign oscEn = oscNeed(curSrc) | (busy ? oscNeed(tgtSrc) : 4'b0000)
               | {keepLprc, secKeep, 2'b00};
  assign pllEn = isPll(curSrc) | (busy & isPll(tgtSrc));

  p_redundant_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startBit && !cfgSwDis && reqSrc == curSrc)
      |=> (state == ST_IDLE));

  p_no_pll_hop_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !(isPll(tgtSrc) && isPll(curSrc)));

  p_target_on_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE) |-> ((oscEn & oscNeed(tgtSrc)) == oscNeed(tgtSrc)));

  p_wait_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_PLL && isPll(tgtSrc) && !pllLock) |=> (state == ST_WAIT_PLL));

endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clksw_pkg::*;
#(
  parameter int SETTLE_CYC  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        newClk,
  input  logic        cfgSwDis,
  input  logic [2:0]  cfgSrc,
  input  logic        keyWr,
  input  logic [7:0]  keyByte,
  input  logic        regWrHi,
  input  logic        regWrLo,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        ostReady,
  input  logic        pllLock,
  input  logic        clkFailIn,
  input  logic        keepLprc,
  input  logic        secKeep,
  output logic [3:0]  oscEn,
  output logic        pllEn,
  output logic [2:0]  clkSel,
  output logic        busy
);
  swStrobe_t        strb;
  logic [SRC_W-1:0] curEff, reqSrc, tgtSrc;
  logic             startBit, settleReq, settleDone;

  clksw_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfgSwDis(cfgSwDis), .cfgSrc(cfgSrc),
    .keyWr(keyWr), .keyByte(keyByte), .regWrHi(regWrHi), .regWrLo(regWrLo),
    .regWrData(regWrData), .clkFailIn(clkFailIn), .strb(strb), .tgtSrc(tgtSrc),
    .curEff(curEff), .reqSrc(reqSrc), .startBit(startBit), .regRdData(regRdData)
  );

  clksw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgSwDis(cfgSwDis), .startBit(startBit),
    .reqSrc(reqSrc), .curSrc(curEff), .ostReady(ostReady), .pllLock(pllLock),
    .settleDone(settleDone), .keepLprc(keepLprc), .secKeep(secKeep),
    .strb(strb), .tgtSrc(tgtSrc), .settleReq(settleReq), .busy(busy),
    .oscEn(oscEn), .pllEn(pllEn)
  );

  clksw_settle #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_settle (
    .clk(clk), .newClk(newClk), .rstN(rstN),
    .settleReq(settleReq), .settleDone(settleDone)
  );

  assign clkSel = curEff;

endmodule

// File: tb/clk_switch_ctrl_bench.sv
module clk_switch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSwDis = 1'b1;
  logic [2:0]  cfgSrc = 3'd5;
  logic        keyWr = 1'b0;
  logic [7:0]  keyByte = '0;
  logic        regWrHi = 1'b0, regWrLo = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        ostReady = 1'b1, pllLock = 1'b1, clkFailIn = 1'b0;
  logic        keepLprc = 1'b0, secKeep = 1'b0;
  logic [3:0]  oscEn;
  logic        pllEn, busy;
  logic [2:0]  clkSel;

  int nVec = 0;
  int nFail = 0;

  always #2 clk = ~clk;   // 250 MHz

  clk_switch_ctrl u_clk_switch_ctrl (
    .clk(clk), .rstN(rstN), .newClk(clk), .cfgSwDis(cfgSwDis), .cfgSrc(cfgSrc),
    .keyWr(keyWr), .keyByte(keyByte), .regWrHi(regWrHi), .regWrLo(regWrLo),
    .regWrData(regWrData), .regRdData(regRdData), .ostReady(ostReady),
    .pllLock(pllLock), .clkFailIn(clkFailIn), .keepLprc(keepLprc),
    .secKeep(secKeep), .oscEn(oscEn), .pllEn(pllEn), .clkSel(clkSel), .busy(busy)
  );

  typedef struct packed {
    logic [2:0] src;
    logic [2:0] cur;
    logic       err;
    logic [3:0] osc;
    logic       pll;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 3'd1, 1'b0, 4'b0001, 1'b1},
    '{3'd3, 3'd1, 1'b1, 4'b0001, 1'b1},
    '{3'd0, 3'd0, 1'b1, 4'b0001, 1'b0},
    '{3'd3, 3'd3, 1'b1, 4'b0010, 1'b1},
    '{3'd5, 3'd5, 1'b1, 4'b1000, 1'b0},
    '{3'd5, 3'd5, 1'b1, 4'b1000, 1'b0},
    '{3'd4, 3'd4, 1'b1, 4'b0100, 1'b0},
    '{3'd2, 3'd2, 1'b1, 4'b0010, 1'b0},
    '{3'd7, 3'd2, 1'b1, 4'b0010, 1'b0}
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic keyPair(input logic [7:0] a, input logic [7:0] b);
    keyWr = 1'b1; keyByte = a; cyc(1);
    keyByte = b; cyc(1);
    keyWr = 1'b0;
  endtask

  task automatic wrHi(input logic [15:0] d);
    regWrData = d; regWrHi = 1'b1; cyc(1); regWrHi = 1'b0;
  endtask

  task automatic wrLo(input logic [15:0] d);
    regWrData = d; regWrLo = 1'b1; cyc(1); regWrLo = 1'b0;
  endtask

  task automatic requestSwitch(input logic [2:0] s);
    keyPair(8'h3C, 8'hC3);
    wrHi({5'b0, s, 8'h00});
    keyPair(8'h5A, 8'hA5);
    wrLo(16'h0001);
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 200 && (busy || regRdData[0]); n++) cyc(1);
  endtask

  task automatic doReset();
    rstN = 1'b0; cyc(2); rstN = 1'b1; cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // ---- switching off by configuration ----
    cyc(1);
    doReset();
    chk("R3 reset reg", regRdData, 16'h5500);
    chk("R1 sel cfg", {13'b0, clkSel}, 16'd5);
    chk("R9 lprc on", {12'b0, oscEn}, 16'b1000);
    requestSwitch(3'd2);
    cyc(25);
    chk("R2 start reads 0", {15'b0, regRdData[0]}, 16'd0);
    chk("R1 sel unchanged", {13'b0, clkSel}, 16'd5);
    chk("R1 req stored only", {13'b0, regRdData[10:8]}, 16'd2);
    cfgSrc = 3'd2; cyc(1);
    chk("R1 cur follows cfg", {13'b0, regRdData[14:12]}, 16'd2);
    chk("R1 sel follows cfg", {13'b0, clkSel}, 16'd2);

    // ---- switching on, unlock rules ----
    cfgSwDis = 1'b0; cfgSrc = 3'd0;
    doReset();
    chk("R3 reset reg on", regRdData, 16'h0000);
    wrHi(16'h0300);
    chk("R4 locked hi", {13'b0, regRdData[10:8]}, 16'd0);
    keyWr = 1'b1; keyByte = 8'h3C; cyc(1);
    keyWr = 1'b0; cyc(1);
    keyWr = 1'b1; keyByte = 8'hC3; cyc(1);
    keyWr = 1'b0;
    wrHi(16'h0300);
    chk("R4 split key", {13'b0, regRdData[10:8]}, 16'd0);
    keyPair(8'h5A, 8'hA5);
    wrHi(16'h0400);
    chk("R4 wrong lane key", {13'b0, regRdData[10:8]}, 16'd0);
    wrLo(16'h0000);
    keyPair(8'h3C, 8'hC3);
    wrHi(16'h0100);
    chk("R4 unlocked hi", {13'b0, regRdData[10:8]}, 16'd1);
    wrHi(16'h0200);
    chk("R4 one write only", {13'b0, regRdData[10:8]}, 16'd1);
    wrLo(16'h0001);
    cyc(3);
    chk("R4 locked lo", {14'b0, busy, regRdData[0]}, 16'd0);
    keyPair(8'h3C, 8'hC3);
    wrHi(16'h0000);

    // ---- vector table ----
    for (int i = 0; i < NV; i++) begin
      requestSwitch(VEC[i].src);
      cyc(3);
      waitIdle();
      chk($sformatf("R8 v%0d cur", i), {13'b0, regRdData[14:12]}, {13'b0, VEC[i].cur});
      chk($sformatf("R8 v%0d sel", i), {13'b0, clkSel}, {13'b0, VEC[i].cur});
      chk($sformatf("R10 v%0d err", i), {15'b0, regRdData[6]}, {15'b0, VEC[i].err});
      chk($sformatf("R9 v%0d en", i), {11'b0, pllEn, oscEn}, {11'b0, VEC[i].pll, VEC[i].osc});
    end

    // ---- exact latency ----
    requestSwitch(3'd4);
    cyc(18);
    chk("R8 old sel at 18", {13'b0, clkSel}, 16'd2);
    chk("R8 start still set", {15'b0, regRdData[0]}, 16'd1);
    cyc(1);
    chk("R8 new sel at 19", {13'b0, clkSel}, 16'd4);
    chk("R8 start cleared", {15'b0, regRdData[0]}, 16'd0);

    // ---- waits on start-up timer and PLL lock ----
    ostReady = 1'b0; pllLock = 1'b0;
    requestSwitch(3'd3);
    cyc(30);
    chk("R7 ost wait", {11'b0, busy, clkSel, 1'b0}, {11'b0, 1'b1, 3'd4, 1'b0});
    chk("R9 target on", {11'b0, pllEn, oscEn}, {11'b0, 1'b1, 4'b0110});
    ostReady = 1'b1; cyc(30);
    chk("R7 pll wait", {12'b0, busy, clkSel}, {12'b0, 1'b1, 3'd4});
    pllLock = 1'b1;
    waitIdle();
    chk("R7 pll done", {13'b0, clkSel}, 16'd3);
    chk("R7 lock set", {15'b0, regRdData[5]}, 16'd1);
    chk("R9 old off", {11'b0, pllEn, oscEn}, {11'b0, 1'b1, 4'b0010});

    // ---- redundant request meets flags, then accepted one clears them ----
    clkFailIn = 1'b1; cyc(1); clkFailIn = 1'b0;
    chk("R6 cf set", {15'b0, regRdData[3]}, 16'd1);
    requestSwitch(3'd3);
    cyc(1);
    chk("R5 abort", {12'b0, busy, regRdData[5], regRdData[3], regRdData[0]},
        {12'b0, 4'b0110});
    requestSwitch(3'd0);
    cyc(1);
    chk("R6 flags cleared", {13'b0, busy, regRdData[5], regRdData[3]}, {13'b0, 3'b100});
    waitIdle();
    chk("R8 to frc", {13'b0, clkSel}, 16'd0);

    // ---- keep-alive enables ----
    keepLprc = 1'b1; secKeep = 1'b1; cyc(1);
    chk("R9 keeps", {12'b0, oscEn}, 16'b1101);
    requestSwitch(3'd2);
    cyc(3);
    waitIdle();
    chk("R9 keeps after", {12'b0, oscEn}, 16'b1110);
    keepLprc = 1'b0; secKeep = 1'b0; cyc(1);
    chk("R9 keeps dropped", {12'b0, oscEn}, 16'b0010);

    summary();
  end

endmodule